// File: doc/BRIEF.md
# Two-Wire Start Detector with Clock Stretching

This block is the bus-condition and wait-state unit for the two-wire mode of a small serial interface. It samples the SDA and SCL bus lines through a short synchroniser. It recognises a start condition, where SDA falls while SCL is high, and a stop condition, where SDA rises while SCL is high. Each condition sets its own sticky flag. The unit can also stretch the bus clock. It asserts an open-drain pull-low request on SCL, and the request stays on until software reacts.

Two events can start a clock hold: a detected start, and an overflow pulse from the shared bit counter. Each cause has its own enable. A hold ends when software clears the flag that caused it. A stop never causes a hold. The start and overflow flags drive interrupt outputs through per-source enables.

The block also provides a wake request for the deepest sleep state, when no clock runs. This request comes straight from the raw pins with no clock involved. It is high while a start is in progress, meaning SCL is high and SDA is low.

Top module: `twi_hold_ctrl`

## Requirements
- R1: After reset, all three flags, both interrupt outputs and `scl_pull_o` are 0.
- R2: With `en_i`=1, if SDA falls while SCL stays high, `start_flag_o` becomes 1 after the third rising clock edge that follows the change on the pins. After only two edges it is still 0.
- R3: If SDA falls while SCL is low, no start flag is set.
- R4: With `en_i`=1, if SDA rises while SCL is high, `stop_flag_o` is set after three edges. A stop by itself never makes `scl_pull_o` 1.
- R5: With `start_hold_en_i`=1, `scl_pull_o` is 1 while the start flag is set. After the clock edge that samples a `clr_start_i` pulse, the start flag and the pull are both 0.
- R6: With `en_i`=1, a one-cycle `cnt_ovf_i` pulse sets `ovf_flag_o` at the next edge. The flag stays set until `clr_ovf_i`. While `ovf_hold_en_i`=1, the set overflow flag makes `scl_pull_o`=1.
- R7: If an event and the clear of its own flag arrive in the same cycle, the event wins and the flag ends up set.
- R8: `start_irq_o` equals `start_flag_o` AND `start_ie_i`. `ovf_irq_o` equals `ovf_flag_o` AND `ovf_ie_i`.
- R9: While `en_i`=0, no flag is set by bus events or overflow pulses, and `scl_pull_o` and `wake_o` are 0.
- R10: `wake_o` is 1 exactly when `en_i`, `start_ie_i` and the raw `scl_i` are 1 and the raw `sda_i` is 0. No clock edge is needed.
- R11: When a hold enable is 0, its flag still sets, but that flag does not pull SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Two-wire mode enable |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| cnt_ovf_i | input | 1 | One-cycle overflow pulse from the bit counter |
| start_hold_en_i | input | 1 | Hold SCL low while the start flag is set |
| ovf_hold_en_i | input | 1 | Hold SCL low while the overflow flag is set |
| start_ie_i | input | 1 | Start interrupt and wake enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| clr_start_i | input | 1 | Clear pulse for the start flag |
| clr_stop_i | input | 1 | Clear pulse for the stop flag |
| clr_ovf_i | input | 1 | Clear pulse for the overflow flag |
| start_flag_o | output | 1 | Sticky start-detected flag |
| stop_flag_o | output | 1 | Sticky stop-detected flag |
| ovf_flag_o | output | 1 | Sticky counter-overflow flag |
| start_irq_o | output | 1 | Start interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |
| scl_pull_o | output | 1 | 1 = drive SCL low (open drain), 0 = release |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
A bus condition takes three rising edges to reach the flags: two synchroniser stages, then the flag register. The condition compares against the delayed copy of the synchronised lines. The checks therefore sample one falling edge after the second and after the third rising edge, which catches both a missing stage and an extra one.

An overflow pulse or a clear pulse reaches its flag one edge after it is sampled. The table entries are applied on one falling edge and checked on the next one. The pull request, the interrupts and the wake request are combinational from the flags and the live inputs, so they are checked in the same sample as the flag, or a few nanoseconds after a pin change for the wake request.

// File: rtl/twi_hold_pkg.sv
package twi_hold_pkg;

    typedef struct packed {
        logic start;
        logic stop;
        logic ovf;
    } twi_flags_t;

    typedef struct packed {
        logic sda;
        logic scl;
    } twi_lines_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    // Idle bus is high, so stages reset to ones.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb pipe_d[s] = d_i;
        end else begin : g_next
            always_comb pipe_d[s] = pipe_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '1;
            else        pipe_q[s] <= pipe_d[s];
        end
    end

    assign q_o = pipe_q[LAST];

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  twi_lines_t lines_i,
    output logic       start_o,
    output logic       stop_o
);
    twi_lines_t prev_d, prev_q;

    always_comb begin
        prev_d  = lines_i;
        // SCL must be high in both samples, and SDA must move.
        start_o = en_i && lines_i.scl && prev_q.scl && prev_q.sda && !lines_i.sda;
        stop_o  = en_i && lines_i.scl && prev_q.scl && !prev_q.sda && lines_i.sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{sda: 1'b1, scl: 1'b1};
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/twi_flag_ctrl.sv
module twi_flag_ctrl
    import twi_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ev_i,
    input  logic       stop_ev_i,
    input  logic       ovf_ev_i,
    input  logic       clr_start_i,
    input  logic       clr_stop_i,
    input  logic       clr_ovf_i,
    output twi_flags_t flags_o
);
    twi_flags_t flags_d, flags_q;

    // Clear first, then set: an event in the same cycle wins.
    always_comb begin
        flags_d = flags_q;
        if (clr_start_i) flags_d.start = 1'b0;
        if (clr_stop_i)  flags_d.stop  = 1'b0;
        if (clr_ovf_i)   flags_d.ovf   = 1'b0;
        if (start_ev_i)  flags_d.start = 1'b1;
        if (stop_ev_i)   flags_d.stop  = 1'b1;
        if (ovf_ev_i)    flags_d.ovf   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev_i |=> flags_q.start);                                  // R2
    AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev_i |=> flags_q.stop);                                    // R4
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev_i |=> flags_q.ovf);                                      // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start_i && !start_ev_i) |=> !flags_q.start);               // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.ovf && !clr_ovf_i) |=> flags_q.ovf);                   // R6

endmodule

// File: rtl/twi_hold_ctrl.sv
module twi_hold_ctrl
    import twi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sda_i,
    input  logic scl_i,
    input  logic cnt_ovf_i,
    input  logic start_hold_en_i,
    input  logic ovf_hold_en_i,
    input  logic start_ie_i,
    input  logic ovf_ie_i,
    input  logic clr_start_i,
    input  logic clr_stop_i,
    input  logic clr_ovf_i,
    output logic start_flag_o,
    output logic stop_flag_o,
    output logic ovf_flag_o,
    output logic start_irq_o,
    output logic ovf_irq_o,
    output logic scl_pull_o,
    output logic wake_o
);
    localparam int LINE_W = $bits(twi_lines_t);

    twi_lines_t lines_s;
    twi_flags_t flags;
    logic       start_ev, stop_ev, ovf_ev;

    twi_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (lines_s)
    );

    twi_cond_detect i_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .lines_i (lines_s),
        .start_o (start_ev),
        .stop_o  (stop_ev)
    );

    assign ovf_ev = cnt_ovf_i && en_i;

    twi_flag_ctrl i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ev_i  (start_ev),
        .stop_ev_i   (stop_ev),
        .ovf_ev_i    (ovf_ev),
        .clr_start_i (clr_start_i),
        .clr_stop_i  (clr_stop_i),
        .clr_ovf_i   (clr_ovf_i),
        .flags_o     (flags)
    );

    always_comb begin
        start_flag_o = flags.start;
        stop_flag_o  = flags.stop;
        ovf_flag_o   = flags.ovf;
        start_irq_o  = flags.start && start_ie_i;
        ovf_irq_o    = flags.ovf && ovf_ie_i;
        scl_pull_o   = en_i && ((flags.start && start_hold_en_i) ||
                                (flags.ovf && ovf_hold_en_i));
        // Clockless path, usable while every clock is stopped.
        wake_o       = en_i && start_ie_i && scl_i && !sda_i;
    end

    AST_PULL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> (start_flag_o || ovf_flag_o));                   // R5
    AST_STOP_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag_o && !start_flag_o && !ovf_flag_o) |-> !scl_pull_o); // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!scl_pull_o && !wake_o));                            // R9
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !ovf_flag_o) |=> !ovf_flag_o);                        // R9

endmodule

// File: tb/test_twi_hold_ctrl.sv
module test_twi_hold_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en, sda, scl, ovf, shen, ohen, sie, oie, clr_s, clr_p, clr_o;
    logic f_start, f_stop, f_ovf, irq_s, irq_o, pull, wake;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    twi_hold_ctrl i_twi_hold_ctrl (
        .clk (clk), .rst_n (rst_n), .en_i (en), .sda_i (sda), .scl_i (scl),
        .cnt_ovf_i (ovf), .start_hold_en_i (shen), .ovf_hold_en_i (ohen),
        .start_ie_i (sie), .ovf_ie_i (oie), .clr_start_i (clr_s),
        .clr_stop_i (clr_p), .clr_ovf_i (clr_o),
        .start_flag_o (f_start), .stop_flag_o (f_stop), .ovf_flag_o (f_ovf),
        .start_irq_o (irq_s), .ovf_irq_o (irq_o), .scl_pull_o (pull),
        .wake_o (wake)
    );

    // Entry bits: {ovf, clr_ovf, ovf_hold_en, ovf_ie, exp_flag, exp_pull, exp_irq}
    localparam logic [6:0] VEC [8] = '{
        7'b1010110,   // R6 pulse sets flag and pull
        7'b0011111,   // R8 irq follows enable
        7'b0111000,   // R6 clear releases
        7'b1111111,   // R7 set beats clear
        7'b0000100,   // R11 no hold enable
        7'b0100000,
        7'b1001101,   // R11 flag and irq, no pull
        7'b0111000
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        en = 1; sda = 1; scl = 1; ovf = 0; shen = 1; ohen = 1;
        sie = 1; oie = 1; clr_s = 0; clr_p = 0; clr_o = 0;
        tick(3);
        chk("R1", "start flag", f_start, 1'b0);
        chk("R1", "ovf flag", f_ovf, 1'b0);
        chk("R1", "pull", pull, 1'b0);
        rst_n = 1;
        tick(4);
        chk("R1", "stop flag", f_stop, 1'b0);
        chk("R1", "irq", irq_s | irq_o, 1'b0);

        // Table: overflow, clear, hold and irq combinations
        for (int k = 0; k < 8; k++) begin
            {ovf, clr_o, ohen, oie} = VEC[k][6:3];
            tick(1);
            chk("R6", $sformatf("vec%0d flag", k), f_ovf, VEC[k][2]);
            chk("R11", $sformatf("vec%0d pull", k), pull, VEC[k][1]);
            chk("R8", $sformatf("vec%0d irq", k), irq_o, VEC[k][0]);
        end
        ovf = 0; clr_o = 0; ohen = 1; oie = 1;

        // Start condition, three-edge latency, wake, hold
        sda = 0;
        #1 chk("R10", "wake on start", wake, 1'b1);
        tick(2);
        chk("R2", "start flag after 2 edges", f_start, 1'b0);
        tick(1);
        chk("R2", "start flag after 3 edges", f_start, 1'b1);
        chk("R5", "pull on start", pull, 1'b1);
        chk("R8", "start irq", irq_s, 1'b1);
        sie = 0;
        #1 chk("R8", "start irq masked", irq_s, 1'b0);
        chk("R10", "wake masked", wake, 1'b0);
        sie = 1;
        clr_s = 1;
        tick(1);
        clr_s = 0;
        chk("R5", "start flag cleared", f_start, 1'b0);
        chk("R5", "pull released", pull, 1'b0);

        // Stop condition: flag, no hold
        sda = 1;
        tick(3);
        chk("R4", "stop flag", f_stop, 1'b1);
        chk("R4", "no pull on stop", pull, 1'b0);
        clr_p = 1;
        tick(1);
        clr_p = 0;
        chk("R4", "stop cleared", f_stop, 1'b0);

        // SDA falls while SCL low: no start
        scl = 0;
        tick(4);
        sda = 0;
        tick(5);
        chk("R3", "no start with SCL low", f_start, 1'b0);
        chk("R3", "no pull", pull, 1'b0);
        sda = 1;
        tick(4);
        scl = 1;
        tick(4);

        // Start with hold disabled
        shen = 0;
        sda = 0;
        tick(3);
        chk("R11", "start flag sets", f_start, 1'b1);
        chk("R11", "no pull without enable", pull, 1'b0);
        clr_s = 1;
        tick(1);
        clr_s = 0;
        shen = 1;
        sda = 1;
        tick(4);
        clr_p = 1;
        tick(1);
        clr_p = 0;

        // Disabled block
        en = 0;
        sda = 0;
        #1 chk("R9", "no wake when disabled", wake, 1'b0);
        tick(4);
        chk("R9", "no start when disabled", f_start, 1'b0);
        ovf = 1;
        tick(1);
        ovf = 0;
        tick(1);
        chk("R9", "no ovf when disabled", f_ovf, 1'b0);
        chk("R9", "no pull when disabled", pull, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule